// File: doc/BRIEF.md
# SIMD Floating-Point Exception Flag Aggregator

This block sits behind a multi-lane packed floating-point unit. The unit delivers results that are already computed, together with the conditions each lane detected. The block combines those lane conditions into one sticky six-bit status field, which it keeps beside a matching six-bit mask field. It decides whether the destination register may be written, and it substitutes a correctly signed infinity in any lane whose overflow is masked. If a condition is not masked, it raises a one-cycle trap strobe in place of the write.

Resolution runs in two phases. The operand-check conditions (invalid, denormal operand, divide-by-zero) are resolved first. If any of them is unmasked, only those conditions are recorded, the destination is not written, and the result-phase conditions are ignored. Otherwise the result-phase conditions (overflow, underflow, inexact) are added to the status. They either allow the write or trap. A tiny result that is exact raises no underflow while underflow is masked.

The block accepts one instruction per cycle through a valid/ready pair. The status update and the destination write both happen in the accepting cycle. A register write has priority over an instruction in the same cycle and stalls it.

Top module: `simd_fp_flag_merge`

## Requirements
- R1: After reset, status_flags is 0, mask_bits is 6'h3F (all masked), in_ready is 1, and trap and dst_we are 0. Status and mask bit order: [0] invalid, [1] denormal, [2] divide-by-zero, [3] overflow, [4] underflow, [5] precision. A mask bit of 1 means the condition is masked.
- R2: Each accepted instruction ORs the lane flags of all lanes into status_flags. The bits are sticky: they stay set across later clean instructions.
- R3: A lane's tiny-result flag raises underflow when underflow is unmasked. When underflow is masked, it raises underflow only if that lane's inexact flag is also set. Result-phase lane bits are 3k+0 overflow, 3k+1 tiny, 3k+2 inexact.
- R4: A lane that reports overflow while overflow is masked drives its dst_res element with the raw result's sign bit, an all-ones exponent and a zero mantissa (binary32 layout), and sets the overflow status bit.
- R5: A lane without an overflow substitution passes its raw result unchanged, and this includes a lane whose denormal operand is masked. Operand-check lane bits are 3k+0 invalid, 3k+1 denormal, 3k+2 divide-by-zero.
- R6: If an unmasked operand-check condition exists in any lane, then only the operand-check flags of all lanes are ORed into status, trap pulses, and dst_we stays 0. Result-phase flags are not recorded.
- R7: If there is no unmasked operand-check condition but a result-phase condition is unmasked, all six flag groups are recorded, trap pulses, and dst_we stays 0.
- R8: If all detected conditions are masked, dst_we is 1 in the accepting cycle and trap is 0. trap and dst_we are never 1 together.
- R9: A register write (csr_wr_en) replaces both status_flags and mask_bits on the next edge and pulls in_ready low. An instruction offered in that cycle is not accepted and leaves no trace.
- R10: While in_valid is 0, trap and dst_we stay 0 and status_flags does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction results and flags present |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| pre_flags | input | LANES*3 | Per-lane operand-check flags |
| post_flags | input | LANES*3 | Per-lane result-phase flags |
| raw_res | input | LANES*DW | Per-lane computed results |
| dst_res | output | LANES*DW | Per-lane results to the destination |
| dst_we | output | 1 | Destination write enable |
| trap | output | 1 | One-cycle exception request |
| csr_wr_en | input | 1 | Register write strobe |
| csr_wr_flags | input | 6 | New status field value |
| csr_wr_mask | input | 6 | New mask field value |
| status_flags | output | 6 | Sticky status field |
| mask_bits | output | 6 | Mask field |

## Verification
The bench uses the defaults: four lanes, a 32-bit lane with an 8-bit exponent and a 23-bit mantissa, and infinity substitution turned on. This configuration lets the bench check exact infinity bit patterns of both signs, and it lets flags from different lanes merge so that their OR becomes visible. Loading the mask field through the register write allows every masked and unmasked combination, including the phase-ordering case where an operand-check trap hides result-phase flags.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
   localparam int NFLAG = 6;
   localparam int NGRP  = 3;
   // status / mask bit positions
   localparam int F_IE = 0;
   localparam int F_DE = 1;
   localparam int F_ZE = 2;
   localparam int F_OE = 3;
   localparam int F_UE = 4;
   localparam int F_PE = 5;
   // result-phase lane bit positions
   localparam int P_OVF  = 0;
   localparam int P_TINY = 1;
   localparam int P_INEX = 2;
   localparam logic [NFLAG-1:0] MASK_RESET = '1;
endpackage

// File: rtl/sfx_lane.sv
module sfx_lane
   import sfx_pkg::*;
#(
   parameter int DW         = 32,
   parameter int EXP_W      = 8,
   parameter int MAN_W      = 23,
   parameter bit INF_ON_OVF = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mask_ovf,
   input  logic            mask_unf,
   input  logic [NGRP-1:0] post_in,
   input  logic [DW-1:0]   raw,
   output logic [NGRP-1:0] post_eff,
   output logic [DW-1:0]   res
);
   logic ovf_sub;

   // tiny-but-exact lanes report no underflow while underflow is masked
   always_comb begin
      post_eff[P_OVF]  = post_in[P_OVF];
      post_eff[P_TINY] = post_in[P_TINY] & (post_in[P_INEX] | ~mask_unf);
      post_eff[P_INEX] = post_in[P_INEX];
   end

   assign ovf_sub = post_in[P_OVF] & mask_ovf;

   generate
      if (INF_ON_OVF) begin : g_inf
         assign res = ovf_sub ? {raw[DW-1], {EXP_W{1'b1}}, {MAN_W{1'b0}}} : raw;

         p_inf_r4: assert property (@(posedge clk) disable iff (!rst_n)
            ovf_sub |-> (res[DW-2:MAN_W] == {EXP_W{1'b1}}) && (res[MAN_W-1:0] == '0)
                        && (res[DW-1] == raw[DW-1]));
      end else begin : g_pass
         assign res = raw;
      end
   endgenerate

   p_uf_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_unf && post_in[P_TINY] && !post_in[P_INEX]) |-> !post_eff[P_TINY]);
endmodule

// File: rtl/sfx_csr.sv
module sfx_csr
   import sfx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [NFLAG-1:0] wr_flags,
   input  logic [NFLAG-1:0] wr_mask,
   input  logic             upd_en,
   input  logic [NFLAG-1:0] upd_bits,
   output logic [NFLAG-1:0] flags,
   output logic [NFLAG-1:0] mask
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
         mask  <= MASK_RESET;
      end else if (wr_en) begin
         flags <= wr_flags;
         mask  <= wr_mask;
      end else if (upd_en) begin
         flags <= flags | upd_bits;
      end
   end

   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ((flags & $past(flags)) == $past(flags)));

   p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(mask));
endmodule

// File: rtl/simd_fp_flag_merge.sv
module simd_fp_flag_merge
   import sfx_pkg::*;
#(
   parameter int LANES      = 4,
   parameter int EXP_W      = 8,
   parameter int MAN_W      = 23,
   parameter int DW         = 32,
   parameter bit INF_ON_OVF = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [LANES*3-1:0]  pre_flags,
   input  logic [LANES*3-1:0]  post_flags,
   input  logic [LANES*DW-1:0] raw_res,
   output logic [LANES*DW-1:0] dst_res,
   output logic                dst_we,
   output logic                trap,
   input  logic                csr_wr_en,
   input  logic [5:0]          csr_wr_flags,
   input  logic [5:0]          csr_wr_mask,
   output logic [5:0]          status_flags,
   output logic [5:0]          mask_bits
);
   localparam int GW = LANES * NGRP;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least 1");
      end
      if (DW != 1 + EXP_W + MAN_W) begin : g_bad_fmt
         $error("DW must equal 1 + EXP_W + MAN_W");
      end
   endgenerate

   logic [GW-1:0]    post_eff;
   logic [NGRP-1:0]  pre_or, post_or;
   logic             accept, pre_unm, post_unm;
   logic [NFLAG-1:0] upd_bits;

   assign in_ready = ~csr_wr_en;
   assign accept   = in_valid & in_ready;

   genvar gl;
   generate
      for (gl = 0; gl < LANES; gl++) begin : g_lane
         sfx_lane #(
            .DW(DW), .EXP_W(EXP_W), .MAN_W(MAN_W), .INF_ON_OVF(INF_ON_OVF)
         ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .mask_ovf (mask_bits[F_OE]),
            .mask_unf (mask_bits[F_UE]),
            .post_in  (post_flags[gl*NGRP +: NGRP]),
            .raw      (raw_res[gl*DW +: DW]),
            .post_eff (post_eff[gl*NGRP +: NGRP]),
            .res      (dst_res[gl*DW +: DW])
         );
      end
   endgenerate

   always_comb begin
      pre_or  = '0;
      post_or = '0;
      for (int i = 0; i < LANES; i++) begin
         pre_or  = pre_or  | pre_flags[i*NGRP +: NGRP];
         post_or = post_or | post_eff[i*NGRP +: NGRP];
      end
   end

   // phase one wins: an unmasked operand check hides the result phase
   assign pre_unm  = |(pre_or  & ~mask_bits[F_ZE:F_IE]);
   assign post_unm = |(post_or & ~mask_bits[F_PE:F_OE]);
   assign upd_bits = pre_unm ? {{NGRP{1'b0}}, pre_or} : {post_or, pre_or};

   assign trap   = accept & (pre_unm | post_unm);
   assign dst_we = accept & ~pre_unm & ~post_unm;

   sfx_csr u_csr (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (csr_wr_en),
      .wr_flags (csr_wr_flags),
      .wr_mask  (csr_wr_mask),
      .upd_en   (accept),
      .upd_bits (upd_bits),
      .flags    (status_flags),
      .mask     (mask_bits)
   );

   p_trap_no_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
      trap |-> !dst_we);

   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |-> (!trap && !dst_we));

   p_pre_hides_post_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && pre_unm) |=> (status_flags[F_PE:F_OE] == $past(status_flags[F_PE:F_OE])));
endmodule

// File: tb/simd_fp_flag_merge_bench.sv
module simd_fp_flag_merge_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic         in_valid = 1'b0, in_ready;
   logic [11:0]  pre_flags = '0, post_flags = '0;
   logic [127:0] raw_res;
   logic [127:0] dst_res;
   logic         dst_we, trap;
   logic         csr_wr_en = 1'b0;
   logic [5:0]   csr_wr_flags = '0, csr_wr_mask = 6'h3F;
   logic [5:0]   status_flags, mask_bits;

   int checks = 0;
   int fails  = 0;

   localparam logic [127:0] RAW = {32'hC0800000, 32'hC0400000, 32'h40000000, 32'h3F800000};

   // {mask, pre, post, exp_we, exp_trap, exp_flags}
   localparam logic [37:0] VEC [0:10] = '{
      {6'h3F, 12'h402, 12'hC40, 1'b1, 1'b0, 6'h3A},
      {6'h3F, 12'h000, 12'h010, 1'b1, 1'b0, 6'h00},
      {6'h2F, 12'h000, 12'h010, 1'b0, 1'b1, 6'h10},
      {6'h3F, 12'h000, 12'h000, 1'b1, 1'b0, 6'h00},
      {6'h3E, 12'h008, 12'h001, 1'b0, 1'b1, 6'h01},
      {6'h3F, 12'h008, 12'h001, 1'b1, 1'b0, 6'h09},
      {6'h37, 12'h000, 12'h200, 1'b0, 1'b1, 6'h08},
      {6'h3F, 12'h100, 12'h000, 1'b1, 1'b0, 6'h04},
      {6'h3B, 12'h100, 12'h020, 1'b0, 1'b1, 6'h04},
      {6'h1F, 12'h000, 12'h020, 1'b0, 1'b1, 6'h20},
      {6'h3D, 12'h802, 12'h000, 1'b0, 1'b1, 6'h06}
   };

   simd_fp_flag_merge u_simd_fp_flag_merge (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .pre_flags(pre_flags), .post_flags(post_flags), .raw_res(raw_res),
      .dst_res(dst_res), .dst_we(dst_we), .trap(trap),
      .csr_wr_en(csr_wr_en), .csr_wr_flags(csr_wr_flags), .csr_wr_mask(csr_wr_mask),
      .status_flags(status_flags), .mask_bits(mask_bits)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act,
                      input logic [127:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [127:0] exp_dst(input logic [5:0] m, input logic [11:0] po);
      logic [127:0] o;
      for (int l = 0; l < 4; l++) begin
         logic [31:0] r;
         r = RAW[l*32 +: 32];
         if (m[3] && po[l*3]) r = {r[31], 8'hFF, 23'h0};
         o[l*32 +: 32] = r;
      end
      return o;
   endfunction

   task automatic csr_write(input logic [5:0] f, input logic [5:0] m);
      @(negedge clk);
      csr_wr_en = 1'b1; csr_wr_flags = f; csr_wr_mask = m;
      @(negedge clk);
      csr_wr_en = 1'b0;
   endtask

   // offer one instruction at a negedge; returns after the accepting edge
   task automatic issue(input logic [11:0] pr, input logic [11:0] po,
                        output logic we_o, output logic tr_o, output logic [127:0] d_o);
      in_valid = 1'b1; pre_flags = pr; post_flags = po;
      #1;
      we_o = dst_we; tr_o = trap; d_o = dst_res;
      @(negedge clk);
      in_valid = 1'b0; pre_flags = '0; post_flags = '0;
      #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic we, tr;
      logic [127:0] d;
      raw_res = RAW;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(status_flags == 6'h00, "R1 status", status_flags, 6'h00);
      chk(mask_bits == 6'h3F, "R1 mask", mask_bits, 6'h3F);
      chk(!trap && !dst_we && in_ready, "R1 strobes", {trap, dst_we, in_ready}, 3'b001);

      // vector table walk
      for (int v = 0; v < 11; v++) begin
         logic [37:0] e;
         e = VEC[v];
         csr_write(6'h00, e[37:32]);
         issue(e[31:20], e[19:8], we, tr, d);
         chk(we == e[7], $sformatf("R8 we vec%0d", v), we, e[7]);
         chk(tr == e[6], $sformatf("R7 trap vec%0d", v), tr, e[6]);
         chk(d == exp_dst(e[37:32], e[19:8]), $sformatf("R4 R5 dst vec%0d", v), d,
             exp_dst(e[37:32], e[19:8]));
         chk(status_flags == e[5:0], $sformatf("R2 R3 R6 flags vec%0d", v),
             status_flags, e[5:0]);
         chk(!trap, $sformatf("R7 trap one cycle vec%0d", v), trap, 1'b0);
      end

      // R4 positive-sign overflow in lane 0
      csr_write(6'h00, 6'h3F);
      issue(12'h000, 12'h001, we, tr, d);
      chk(d[31:0] == 32'h7F800000, "R4 positive inf", d[31:0], 32'h7F800000);
      chk(d[127:32] == RAW[127:32], "R5 other lanes raw", d[127:32], RAW[127:32]);

      // R2 stickiness across instructions
      csr_write(6'h00, 6'h3F);
      issue(12'h002, 12'h000, we, tr, d);
      issue(12'h000, 12'h020, we, tr, d);
      chk(status_flags == 6'h22, "R2 accumulate", status_flags, 6'h22);
      issue(12'h000, 12'h000, we, tr, d);
      chk(status_flags == 6'h22, "R2 sticky after clean", status_flags, 6'h22);

      // R10 idle with flags on the inputs
      pre_flags = 12'hFFF; post_flags = 12'hFFF;
      #1;
      chk(!trap && !dst_we, "R10 idle strobes", {trap, dst_we}, 2'b00);
      @(negedge clk);
      #1;
      chk(status_flags == 6'h22, "R10 flags unchanged", status_flags, 6'h22);
      pre_flags = '0; post_flags = '0;

      // R9 register write stalls a concurrent instruction
      @(negedge clk);
      csr_wr_en = 1'b1; csr_wr_flags = 6'h15; csr_wr_mask = 6'h2A;
      in_valid = 1'b1; pre_flags = 12'h001;
      #1;
      chk(!in_ready && !trap && !dst_we, "R9 stall", {in_ready, trap, dst_we}, 3'b000);
      @(negedge clk);
      csr_wr_en = 1'b0; in_valid = 1'b0; pre_flags = '0;
      #1;
      chk(status_flags == 6'h15, "R9 flags loaded", status_flags, 6'h15);
      chk(mask_bits == 6'h2A, "R9 mask loaded", mask_bits, 6'h2A);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule